// File: doc/BRIEF.md
# Multi-size TLB with protection check

This block is a small fully associative translation buffer that turns a 32-bit virtual address into a physical address. Each of its entries maps one virtual page to one physical frame. A per-entry size code chooses a 4 KiB, 64 KiB, 1 MiB or 4 MiB page. The size code becomes a don't-care mask: the mask hides the low page-number bits from the tag compare, and the same bits of the virtual address pass straight into the physical address, because a large frame is physically contiguous.

Every hit is also checked against the entry's rights. The entry holds separate read, write and execute permissions and a kernel-only flag. A user-mode access to a kernel-only page faults, and so does any access the permissions do not allow. A fault hides the translation and changes no entry.

An external refill agent writes entries through a fill port. Fills go to slots chosen round-robin. An invalidate-all input empties the buffer in one cycle. A lookup is presented for one cycle, and its result appears on registered outputs at the next clock edge.

Top module: `pgx_tlb`

## Requirements
- R1: While reset is held and after it is released, every entry is invalid, `rsp_valid` is 0 and lookups miss until a fill is made.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. With no request, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0.
- R3: Size code 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = 4 MiB. The tag compare ignores the low 0, 4, 8 or 10 bits of the virtual page number (address bits 31:12) for these codes.
- R4: On a hit with no fault, the physical address is the entry frame number with its masked low bits replaced by the same virtual page-number bits, followed by the unchanged address bits 11:0.
- R5: On a miss, `rsp_hit`, `rsp_fault` and `rsp_pa` are all 0.
- R6: `lk_acc` codes are 0 read, 1 write and 2 execute. An access whose permission bit (`fill_perm[2]` read, `[1]` write, `[0]` execute) is clear faults. Code 3 always faults on a hit.
- R7: An entry filled with `fill_kern` = 1 faults on any access with `lk_user` = 1, and obeys only R6 when `lk_user` = 0.
- R8: On a fault, `rsp_hit` = 1, `rsp_fault` = 1 and `rsp_pa` = 0, and no entry state changes.
- R9: Fills write slots in round-robin order. The slot pointer starts at 0 after reset, moves on by one on every fill, and wraps from 7 to 0.
- R10: `inv_all` clears every valid bit in one cycle and sets the slot pointer to 0. A fill in the same cycle is dropped.
- R11: When more than one valid entry matches, the lowest-indexed entry gives the result.
- R12: A lookup in the same cycle as a fill or `inv_all` sees the entries as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| fill_en | input | 1 | Write one entry at the round-robin slot |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_pfn | input | 20 | Physical frame number of the new entry |
| fill_size | input | 2 | Page size code of the new entry |
| fill_perm | input | 3 | Read, write, execute permissions (bits 2,1,0) |
| fill_kern | input | 1 | Kernel-only page |
| inv_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_fault | output | 1 | Protection fault on the hit |
| rsp_pa | output | 32 | Translated physical address |

## Verification
On every cycle the assertions check the response timing against the request, that a fault always comes with a hit, that a miss or fault gives a zero address, that the page offset passes through on good hits, and that a lookup right after an invalidate misses. Only the bench's scenarios can show the masked compare for each size code, the address merge of large pages, each permission and kernel-only fault, lowest-index priority between overlapping entries, the round-robin order with its wrap, the pointer reset by an invalidate, and the view a lookup has of the entries when a fill happens in the same cycle. For these the bench compares every response against a behavioural model of the entries.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   // widest don't-care span over the virtual page number (4 MiB over 4 KiB)
   localparam int XMAX = 10;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_e;

   // page-size code -> don't-care mask over the low page-number bits
   function automatic logic [XMAX-1:0] size_mask(input logic [1:0] code);
      logic [XMAX-1:0] m;
      case (code)
         2'd0:    m = '0;
         2'd1:    m = XMAX'(10'h00F);
         2'd2:    m = XMAX'(10'h0FF);
         default: m = XMAX'(10'h3FF);
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pgx_store.sv
module pgx_store #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            inv_all,
   input  logic                            fill_en,
   input  logic [VPN_W-1:0]                fill_vpn,
   input  logic [PFN_W-1:0]                fill_pfn,
   input  logic [1:0]                      fill_size,
   input  logic [2:0]                      fill_perm,
   input  logic                            fill_kern,
   output logic [ENTRIES-1:0]              e_vld,
   output logic [ENTRIES-1:0][VPN_W-1:0]   e_vpn,
   output logic [ENTRIES-1:0][PFN_W-1:0]   e_pfn,
   output logic [ENTRIES-1:0][1:0]         e_size,
   output logic [ENTRIES-1:0][2:0]         e_perm,
   output logic [ENTRIES-1:0]              e_kern
);

   localparam int  PTR_W  = $clog2(ENTRIES);
   localparam bit  IS_P2  = ((1 << PTR_W) == ENTRIES);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_nx;

   // pointer wrap: free-running when the depth is a power of two
   generate
      if (IS_P2) begin : g_wrap_p2
         assign ptr_nx = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nx = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr_q <= '0;
      else if (inv_all)    ptr_q <= '0;
      else if (fill_en)    ptr_q <= ptr_nx;
   end

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         logic             v_q;
         logic [VPN_W-1:0] vpn_q;
         logic [PFN_W-1:0] pfn_q;
         logic [1:0]       sz_q;
         logic [2:0]       perm_q;
         logic             kern_q;
         logic             wr_sel;

         assign wr_sel = fill_en && !inv_all && (ptr_q == PTR_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q    <= 1'b0;
               vpn_q  <= '0;
               pfn_q  <= '0;
               sz_q   <= '0;
               perm_q <= '0;
               kern_q <= 1'b0;
            end else if (inv_all) begin
               v_q    <= 1'b0;
            end else if (wr_sel) begin
               v_q    <= 1'b1;
               vpn_q  <= fill_vpn;
               pfn_q  <= fill_pfn;
               sz_q   <= fill_size;
               perm_q <= fill_perm;
               kern_q <= fill_kern;
            end
         end

         assign e_vld[i]  = v_q;
         assign e_vpn[i]  = vpn_q;
         assign e_pfn[i]  = pfn_q;
         assign e_size[i] = sz_q;
         assign e_perm[i] = perm_q;
         assign e_kern[i] = kern_q;
      end
   endgenerate

endmodule

// File: rtl/pgx_match.sv
module pgx_match
   import pgx_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20
) (
   input  logic [VPN_W-1:0]                lk_vpn,
   input  logic [ENTRIES-1:0]              e_vld,
   input  logic [ENTRIES-1:0][VPN_W-1:0]   e_vpn,
   input  logic [ENTRIES-1:0][PFN_W-1:0]   e_pfn,
   input  logic [ENTRIES-1:0][1:0]         e_size,
   input  logic [ENTRIES-1:0][2:0]         e_perm,
   input  logic [ENTRIES-1:0]              e_kern,
   output logic                            m_hit,
   output logic [PFN_W-1:0]                m_pfn,
   output logic [XMAX-1:0]                 m_mask,
   output logic [2:0]                      m_perm,
   output logic                            m_kern
);

   localparam int HI_W = VPN_W - XMAX;

   logic [ENTRIES-1:0]            hv;
   logic [ENTRIES-1:0][XMAX-1:0]  msk;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
         logic [VPN_W-1:0] care;
         assign msk[i] = size_mask(e_size[i]);
         assign care   = {{HI_W{1'b1}}, ~msk[i]};
         assign hv[i]  = e_vld[i] && (((e_vpn[i] ^ lk_vpn) & care) == '0);
      end
   endgenerate

   // walk from the top so the lowest matching index is written last
   always_comb begin
      m_hit  = 1'b0;
      m_pfn  = '0;
      m_mask = '0;
      m_perm = '0;
      m_kern = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hv[i]) begin
            m_hit  = 1'b1;
            m_pfn  = e_pfn[i];
            m_mask = msk[i];
            m_perm = e_perm[i];
            m_kern = e_kern[i];
         end
      end
   end

endmodule

// File: rtl/pgx_rights.sv
module pgx_rights
   import pgx_pkg::*;
(
   input  logic [2:0] perm,
   input  logic       kern,
   input  logic [1:0] acc,
   input  logic       user,
   output logic       deny
);

   logic type_ok;

   always_comb begin
      case (acc_e'(acc))
         ACC_RD:  type_ok = perm[2];
         ACC_WR:  type_ok = perm[1];
         ACC_EX:  type_ok = perm[0];
         default: type_ok = 1'b0;
      endcase
   end

   assign deny = !type_ok || (user && kern);

endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb
   import pgx_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lk_valid,
   input  logic [VA_W-1:0]       lk_va,
   input  logic [1:0]            lk_acc,
   input  logic                  lk_user,
   input  logic                  fill_en,
   input  logic [VA_W-OFF_W-1:0] fill_vpn,
   input  logic [PA_W-OFF_W-1:0] fill_pfn,
   input  logic [1:0]            fill_size,
   input  logic [2:0]            fill_perm,
   input  logic                  fill_kern,
   input  logic                  inv_all,
   output logic                  rsp_valid,
   output logic                  rsp_hit,
   output logic                  rsp_fault,
   output logic [PA_W-1:0]       rsp_pa
);

   localparam int VPN_W = VA_W - OFF_W;
   localparam int PFN_W = PA_W - OFF_W;

   initial begin : p_param_chk
      assert (ENTRIES >= 2)   else $error("pgx_tlb: ENTRIES must be at least 2");
      assert (VPN_W > XMAX)   else $error("pgx_tlb: VA_W too small for largest page");
      assert (PFN_W > XMAX)   else $error("pgx_tlb: PA_W too small for largest page");
   end

   logic [ENTRIES-1:0]              e_vld;
   logic [ENTRIES-1:0][VPN_W-1:0]   e_vpn;
   logic [ENTRIES-1:0][PFN_W-1:0]   e_pfn;
   logic [ENTRIES-1:0][1:0]         e_size;
   logic [ENTRIES-1:0][2:0]         e_perm;
   logic [ENTRIES-1:0]              e_kern;

   logic             m_hit;
   logic [PFN_W-1:0] m_pfn;
   logic [XMAX-1:0]  m_mask;
   logic [2:0]       m_perm;
   logic             m_kern;
   logic             deny;

   logic [VPN_W-1:0] lk_vpn;
   logic [XMAX-1:0]  frame_lo;
   logic [PA_W-1:0]  pa_c;

   assign lk_vpn = lk_va[VA_W-1:OFF_W];

   pgx_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
      .fill_size(fill_size), .fill_perm(fill_perm), .fill_kern(fill_kern),
      .e_vld(e_vld), .e_vpn(e_vpn), .e_pfn(e_pfn),
      .e_size(e_size), .e_perm(e_perm), .e_kern(e_kern)
   );

   pgx_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_match (
      .lk_vpn(lk_vpn), .e_vld(e_vld), .e_vpn(e_vpn), .e_pfn(e_pfn),
      .e_size(e_size), .e_perm(e_perm), .e_kern(e_kern),
      .m_hit(m_hit), .m_pfn(m_pfn), .m_mask(m_mask),
      .m_perm(m_perm), .m_kern(m_kern)
   );

   pgx_rights u_rights (
      .perm(m_perm), .kern(m_kern), .acc(lk_acc), .user(lk_user), .deny(deny)
   );

   // contiguous frame: masked low bits come from the virtual page number
   assign frame_lo = (m_pfn[XMAX-1:0] & ~m_mask) | (lk_vpn[XMAX-1:0] & m_mask);
   assign pa_c     = {m_pfn[PFN_W-1:XMAX], frame_lo, lk_va[OFF_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= lk_valid && m_hit;
         rsp_fault <= lk_valid && m_hit && deny;
         rsp_pa    <= (lk_valid && m_hit && !deny) ? pa_c : '0;
      end
   end

endmodule

// File: rtl/pgx_tlb_chk.sv
module pgx_tlb_chk #(
   parameter int PA_W  = 32,
   parameter int OFF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [OFF_W-1:0] lk_off,
   input logic             inv_all,
   input logic             rsp_valid,
   input logic             rsp_hit,
   input logic             rsp_fault,
   input logic [PA_W-1:0]  rsp_pa
);

   logic inv_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inv_d <= 1'b0;
      else        inv_d <= inv_all;
   end

   a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);

   a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

   a_r8_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_hit);

   a_r5_r8_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (!rsp_hit || rsp_fault)) |-> (rsp_pa == '0));

   a_r4_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == $past(lk_off)));

   a_r10_miss_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_d && lk_valid) |=> !rsp_hit);

endmodule

bind pgx_tlb pgx_tlb_chk #(.PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_off(lk_va[OFF_W-1:0]),
   .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
   .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/sim_pgx_tlb.sv
`timescale 1ns/1ps
module sim_pgx_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_user = 1'b0;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_pfn = '0;
   logic [1:0]  fill_size = '0;
   logic [2:0]  fill_perm = '0;
   logic        fill_kern = 1'b0;
   logic        inv_all = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_fault;
   logic [31:0] rsp_pa;

   always #2.5 clk = ~clk;

   pgx_tlb u0 (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
      .lk_acc(lk_acc), .lk_user(lk_user), .fill_en(fill_en),
      .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_size(fill_size),
      .fill_perm(fill_perm), .fill_kern(fill_kern), .inv_all(inv_all),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_pa(rsp_pa)
   );

   // behavioural model of the entries
   bit          mv [8];
   bit [19:0]   mvpn [8];
   bit [19:0]   mpfn [8];
   bit [1:0]    msz [8];
   bit [2:0]    mperm [8];
   bit          mk [8];
   int          mptr;

   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   string       scen = "R1";
   bit          ex_v = 1'b0, ex_h = 1'b0, ex_f = 1'b0;
   bit [31:0]   ex_pa = '0;
   string       ex_tag = "R1";

   function automatic int xbits(bit [1:0] c);
      return (c == 0) ? 0 : (c == 1) ? 4 : (c == 2) ? 8 : 10;
   endfunction

   task automatic model_lookup(input bit [31:0] va, input bit [1:0] acc, input bit usr);
      bit [19:0] vpn = va[31:12];
      ex_h = 0; ex_f = 0; ex_pa = 0; ex_tag = "R5";
      for (int i = 0; i < 8; i++) begin
         bit [19:0] m = 20'((1 << xbits(msz[i])) - 1);
         if (mv[i] && ((mvpn[i] & ~m) == (vpn & ~m))) begin
            bit ok;
            ex_h = 1;
            ok = (acc == 0) ? mperm[i][2] : (acc == 1) ? mperm[i][1] :
                 (acc == 2) ? mperm[i][0] : 1'b0;
            if (usr && mk[i]) begin
               ex_f = 1; ex_tag = "R7";
            end else if (!ok) begin
               ex_f = 1; ex_tag = "R6";
            end else begin
               ex_pa  = {((mpfn[i] & ~m) | (vpn & m)), va[11:0]};
               ex_tag = (msz[i] == 0) ? "R3" : "R4";
            end
            break;
         end
      end
   endtask

   task automatic compare();
      n_cmp++;
      if (rsp_valid !== ex_v) begin
         n_bad++;
         $display("FAIL [R2/%s] rsp_valid actual=%0b expected=%0b", scen, rsp_valid, ex_v);
      end
      if (ex_v) begin
         n_cmp += 3;
         if (rsp_hit !== ex_h) begin
            n_bad++;
            $display("FAIL [%s/%s] rsp_hit actual=%0b expected=%0b", ex_tag, scen, rsp_hit, ex_h);
         end
         if (rsp_fault !== ex_f) begin
            n_bad++;
            $display("FAIL [%s/%s] rsp_fault actual=%0b expected=%0b", ex_tag, scen, rsp_fault, ex_f);
         end
         if (rsp_pa !== ex_pa) begin
            n_bad++;
            $display("FAIL [%s/%s] rsp_pa actual=%08h expected=%08h", ex_tag, scen, rsp_pa, ex_pa);
         end
      end
   endtask

   task automatic step(input bit lv, input bit [31:0] va, input bit [1:0] acc, input bit usr,
                       input bit fe, input bit [19:0] fv, input bit [19:0] fp, input bit [1:0] fs,
                       input bit [2:0] fperm, input bit fk, input bit inv);
      @(negedge clk);
      compare();
      lk_valid = lv; lk_va = va; lk_acc = acc; lk_user = usr;
      fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_size = fs;
      fill_perm = fperm; fill_kern = fk; inv_all = inv;
      ex_v = lv;
      if (lv) model_lookup(va, acc, usr);
      else begin ex_h = 0; ex_f = 0; ex_pa = 0; end
      if (inv) begin
         for (int i = 0; i < 8; i++) mv[i] = 0;
         mptr = 0;
      end else if (fe) begin
         mv[mptr] = 1; mvpn[mptr] = fv; mpfn[mptr] = fp;
         msz[mptr] = fs; mperm[mptr] = fperm; mk[mptr] = fk;
         mptr = (mptr + 1) % 8;
      end
   endtask

   task automatic look(input bit [31:0] va, input bit [1:0] acc, input bit usr);
      step(1, va, acc, usr, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic fill(input bit [19:0] fv, input bit [19:0] fp, input bit [1:0] fs,
                       input bit [2:0] fperm, input bit fk);
      step(0, 0, 0, 0, 1, fv, fp, fs, fperm, fk, 0);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL [R2] watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 8; i++) mv[i] = 0;
      mptr = 0;
      // R1: outputs quiet while reset is held
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;

      // R1 / R5: empty buffer misses
      scen = "R1";
      look(32'h0001_2ABC, 0, 1);
      idle();

      // R3: basic page, R2 idle cycles in between
      scen = "R3";
      fill(20'h00012, 20'h00345, 0, 3'b111, 0);
      look(32'h0001_2ABC, 0, 1);
      look(32'h0001_3ABC, 0, 1);

      // R4 / R6: 64 KiB shared read-only page
      scen = "R4";
      fill(20'h00120, 20'h00560, 1, 3'b100, 0);
      look(32'h0012_7F00, 0, 1);
      scen = "R6";
      look(32'h0012_7F00, 1, 1);
      look(32'h0012_F004, 2, 0);

      // R7: 1 MiB kernel-only execute page
      scen = "R7";
      fill(20'h30000, 20'h40000, 2, 3'b001, 1);
      look(32'h300A_B123, 2, 0);
      look(32'h300A_B123, 2, 1);
      scen = "R6";
      look(32'h300A_B123, 0, 0);

      // R3 / R6: 4 MiB page, reserved access code
      scen = "R3";
      fill(20'h80000, 20'h90000, 3, 3'b110, 0);
      look(32'h8034_5678, 1, 1);
      look(32'h8040_0000, 0, 1);
      scen = "R6";
      look(32'h8034_5678, 3, 0);

      // R11: overlapping 4 KiB entry at a higher index loses
      scen = "R11";
      fill(20'h80345, 20'h11111, 0, 3'b111, 0);
      look(32'h8034_5678, 0, 1);

      // R8: faults change nothing; a good access afterwards still translates
      scen = "R8";
      look(32'h0012_7F00, 1, 1);
      look(32'h0012_7F00, 1, 0);
      look(32'h0012_7F00, 0, 1);

      // R9: fill slots 5..7, then wrap to slot 0 which now wins the overlap
      scen = "R9";
      fill(20'hA0000, 20'h0A000, 0, 3'b100, 0);
      fill(20'hB0000, 20'h0B000, 0, 3'b100, 0);
      fill(20'hC0000, 20'h0C000, 0, 3'b100, 0);
      look(32'hC000_0010, 0, 0);
      fill(20'h80345, 20'h22222, 0, 3'b111, 0);
      look(32'h8034_5678, 0, 1);
      look(32'h0001_2ABC, 0, 1);

      // R12: lookup in the fill cycle sees the old slot 1
      scen = "R12";
      step(1, 32'h0012_7F00, 0, 1, 1, 20'h00127, 20'h77777, 0, 3'b111, 0, 0);
      look(32'h0012_7F00, 0, 1);
      look(32'h0012_6F00, 0, 1);

      // R10: move pointer to 7, invalidate with a dropped fill
      scen = "R10";
      repeat (5) fill(20'hD0000, 20'h0D000, 0, 3'b100, 0);
      step(1, 32'h8034_5678, 0, 1, 1, 20'h55555, 20'h00999, 0, 3'b111, 0, 1);
      look(32'h8034_5678, 0, 1);
      look(32'h5555_5000, 0, 1);
      fill(20'h55555, 20'h00001, 0, 3'b111, 0);
      fill(20'h55555, 20'h00002, 0, 3'b111, 0);
      look(32'h5555_5123, 0, 1);
      look(32'hD000_0000, 0, 0);

      idle();
      idle();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule